// File: doc/BRIEF.md
# Real-Time-Clock Divider and Seconds Counter

This block is the front end of a real-time clock. A 128 Hz enable pulse drives a seven-stage binary divider. Its stages, from 64 Hz down to 1 Hz, are visible as an 8-bit read-only value. Each time the divider wraps from all ones to zero, a BCD seconds value steps by one. Software can read the seconds value, and can write it while counting is halted. When the seconds roll over from 59 to 00, the block emits a one-cycle minute-carry pulse for a minute counter further down the chain.

Three software controls steer the block:

- A run bit starts and stops counting.
- A divider-clear strobe zeroes the divider.
- An adjust strobe rounds the time to the nearest minute.

The system reset clears only the carry output. The divider and the seconds value keep running through a reset, so timekeeping survives a chip reset.

Top module: `rtc_sec_front`

## Requirements
- R1: While `run` is 1, each cycle with `tick` high adds one to the 7-bit divider held in `div_q[6:0]`, which wraps from 127 to 0. Bit 0 is the 64 Hz stage and bit 6 is the 1 Hz stage. `div_q[7]` always reads 0.
- R2: `sec_q` holds BCD, with the tens digit in bits 6:4 and the units digit in bits 3:0. Bit 7 reads 0. The value steps by one, with a decimal carry from units into tens, in the cycle where a counted tick wraps the divider from 127 to 0.
- R3: A step from 59 gives 00. `min_carry` is then 1 for exactly the one cycle that follows that clock edge.
- R4: While `run` is 0, ticks have no effect. The divider and the seconds hold their values, and only `adjust` can raise `min_carry`.
- R5: When `div_clr` is high at an edge, the divider becomes 0 and that tick is not counted. The seconds value is unchanged by the clear.
- R6: When `adjust` is high at an edge, the divider and the seconds both become 0. `min_carry` is raised for one cycle when the tens digit was 3 or more, and stays 0 otherwise. `adjust` takes precedence over `div_clr`, over writes and over counting.
- R7: A write (`wr_en` high) while `run` is 0 stores `{1'b0, wr_data[6:0]}` into the seconds. A write while `run` is 1 is ignored.
- R8: A stored value whose units digit is above 9 or whose tens digit is above 5 steps to 00 on its next increment, with no minute carry.
- R9: `rst_n` low clears only `min_carry`. The divider and the seconds keep their values, and they keep counting while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset (clears the carry output only) |
| tick | input | 1 | 128 Hz enable pulse, one cycle wide |
| run | input | 1 | Counting enable (start bit) |
| div_clr | input | 1 | Divider clear strobe |
| adjust | input | 1 | Round-to-minute strobe |
| wr_en | input | 1 | Seconds write strobe |
| wr_data | input | 8 | Seconds write data (BCD) |
| div_q | output | 8 | Divider readback: 64 Hz stage in bit 0 through 1 Hz stage in bit 6, bit 7 zero |
| sec_q | output | 8 | Seconds readback (BCD) |
| min_carry | output | 1 | One-cycle minute carry |

## Verification
The bench drives the rollover from 59 with the divider at 127. A design that places the carry on the wrong edge, or holds it for more than one cycle, gives a shifted or stretched pulse.

It also covers these cases, each with the failure it would expose:

- **Adjust at the 29/30 boundary.** This exposes an off-by-one in the rounding rule.
- **Illegal seconds values such as 4A and 65.** A design that lacks the wrap-to-zero would walk into further illegal codes.
- **Writes while running.** A design that ignores the run bit for writes would corrupt the count.
- **Reset in mid-count.** A design that resets its counters on the system reset would lose time.

Random control traffic mixes clears, adjusts and writes with ticks, so that conflicting strobes in one cycle test the priority order.

// File: rtl/rtc_sec_front.sv
module rtc_sec_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       div_clr,
  input  logic       adjust,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] div_q,
  output logic [7:0] sec_q,
  output logic       min_carry
);
  localparam int DIV_W = 7;

  logic [DIV_W-1:0] div_r;
  logic [3:0]       units_r;
  logic [2:0]       tens_r;

  wire step     = run & tick & ~adjust & ~div_clr;
  wire roll     = step & (&div_r);
  wire bad      = (units_r > 4'd9) || (tens_r > 3'd5);
  wire last     = (tens_r == 3'd5) && (units_r == 4'd9);
  wire round_up = tens_r >= 3'd3;

  always_ff @(posedge clk) begin
    if (adjust || div_clr)
      div_r <= '0;
    else if (step)
      div_r <= div_r + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (adjust) begin
      tens_r  <= '0;
      units_r <= '0;
    end else if (wr_en && !run) begin
      tens_r  <= wr_data[6:4];
      units_r <= wr_data[3:0];
    end else if (roll) begin
      if (bad || last) begin
        tens_r  <= '0;
        units_r <= '0;
      end else if (units_r == 4'd9) begin
        tens_r  <= tens_r + 1'b1;
        units_r <= '0;
      end else begin
        units_r <= units_r + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      min_carry <= 1'b0;
    else
      min_carry <= adjust ? round_up : (roll & last & ~bad);
  end

  assign div_q = {1'b0, div_r};
  assign sec_q = {1'b0, tens_r, units_r};
endmodule

module rtc_sec_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       run,
  input logic       div_clr,
  input logic       adjust,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] div_q,
  input logic [7:0] sec_q,
  input logic       min_carry
);
  p_div_msb_zero_r1: assert property (@(posedge clk) div_q[7] == 1'b0);

  p_sec_msb_zero_r2: assert property (@(posedge clk) sec_q[7] == 1'b0);

  p_tick_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !div_clr && !adjust) |=> div_q[6:0] == $past(div_q[6:0]) + 7'd1);

  p_carry_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    min_carry |-> sec_q == 8'h00);

  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !div_clr && !adjust) |=> $stable(div_q));

  p_no_carry_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !adjust) |=> !min_carry);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_clr |=> div_q == 8'h00);

  p_adjust_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adjust |=> (sec_q == 8'h00 && div_q == 8'h00));

  p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !run && !adjust) |=> sec_q == {1'b0, $past(wr_data[6:0])});
endmodule

bind rtc_sec_front rtc_sec_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .div_clr(div_clr),
  .adjust(adjust), .wr_en(wr_en), .wr_data(wr_data), .div_q(div_q),
  .sec_q(sec_q), .min_carry(min_carry)
);

// File: tb/rtc_sec_front_tb_top.sv
module rtc_sec_front_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, div_clr = 1'b0, adjust = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] div_q, sec_q;
  logic       min_carry;

  int n_run = 0, n_fail = 0;
  bit chk = 1'b0;
  bit done = 1'b0;
  logic [6:0] m_div = '0;
  logic [7:0] m_sec = '0;
  logic       m_carry = 1'b0;

  always #4 clk = ~clk;

  rtc_sec_front dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .div_clr(div_clr),
    .adjust(adjust), .wr_en(wr_en), .wr_data(wr_data), .div_q(div_q),
    .sec_q(sec_q), .min_carry(min_carry)
  );

  function automatic logic [8:0] sec_inc(input logic [7:0] s);
    if (s[3:0] > 4'd9 || s[6:4] > 3'd5) return 9'h000;
    if (s == 8'h59) return {1'b1, 8'h00};
    if (s[3:0] == 4'd9) return {1'b0, 1'b0, s[6:4] + 3'd1, 4'd0};
    return {1'b0, s[7:4], s[3:0] + 4'd1};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [16:0] act, input logic [16:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit r, input bit t, input bit c, input bit a,
                     input bit w, input logic [7:0] d, input string tag);
    logic [8:0] nx;
    logic       nc;
    run = r; tick = t; div_clr = c; adjust = a; wr_en = w; wr_data = d;
    @(posedge clk);
    #2;
    nc = 1'b0;
    if (a) begin
      nc = m_sec[6:4] >= 3'd3;
      m_div = '0;
      m_sec = '0;
    end else begin
      if (c) m_div = '0;
      else if (r && t) begin
        if (m_div == 7'h7F) begin
          nx = sec_inc(m_sec);
          m_sec = nx[7:0];
          nc = nx[8];
        end
        m_div = m_div + 7'd1;
      end
      if (w && !r) m_sec = {1'b0, d[6:0]};
    end
    m_carry = rst_n ? nc : 1'b0;
    if (chk)
      check({div_q, sec_q, min_carry} == {1'b0, m_div, m_sec, m_carry}, tag,
            {div_q, sec_q, min_carry}, {1'b0, m_div, m_sec, m_carry});
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic set_sec(input logic [7:0] v, input string tag);
    cyc(0, 0, 1, 0, 1, v, tag);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) cyc(0, 0, 0, 0, 0, 8'h00, "init");
    cyc(0, 0, 0, 1, 0, 8'h00, "init");
    cyc(0, 0, 0, 0, 0, 8'h00, "init");
    check(min_carry == 1'b0, "R9 reset carry", {16'h0, min_carry}, 17'h0);
    rst_n = 1'b1;
    chk = 1'b1;
    cyc(0, 0, 0, 0, 0, 8'h00, "R4 idle");

    set_sec(8'h57, "R7 write stopped");
    set_sec(8'hD5, "R7 bit7 dropped");
    cyc(1, 0, 0, 0, 1, 8'h12, "R7 write while running ignored");
    cyc(0, 1, 0, 0, 0, 8'h00, "R4 tick ignored when stopped");

    ticks(300, "R1 R2 counting");
    repeat (20) cyc(0, 1, 0, 0, 0, 8'h00, "R4 hold");
    cyc(1, 1, 1, 0, 0, 8'h00, "R5 clear beats tick");

    set_sec(8'h59, "R3 preset 59");
    ticks(128, "R3 rollover carry");
    check(min_carry == 1'b1 && sec_q == 8'h00, "R3 carry after 59",
          {8'h0, sec_q, min_carry}, 17'h1);
    ticks(2, "R3 single pulse");

    set_sec(8'h09, "R2 preset 09");
    ticks(128, "R2 units to tens");
    check(sec_q == 8'h10, "R2 09 to 10", {9'h0, sec_q}, 17'h10);

    set_sec(8'h31, "R6 preset 31");
    cyc(0, 0, 0, 1, 0, 8'h00, "R6 adjust up");
    set_sec(8'h30, "R6 preset 30");
    cyc(1, 1, 1, 1, 1, 8'h44, "R6 adjust precedence");
    cyc(0, 0, 0, 0, 0, 8'h00, "R6 idle");
    set_sec(8'h29, "R6 preset 29");
    cyc(0, 0, 0, 1, 0, 8'h00, "R6 adjust down");
    check(min_carry == 1'b0, "R6 no carry at 29", {16'h0, min_carry}, 17'h0);

    set_sec(8'h4A, "R8 preset 4A");
    ticks(128, "R8 invalid units wrap");
    check(sec_q == 8'h00 && !min_carry, "R8 4A to 00",
          {8'h0, sec_q, min_carry}, 17'h0);
    set_sec(8'h65, "R8 preset 65");
    ticks(128, "R8 invalid tens wrap");

    ticks(40, "R9 pre");
    rst_n = 1'b0;
    ticks(5, "R9 counting during reset");
    rst_n = 1'b1;
    ticks(5, "R9 after reset");

    for (int i = 0; i < 6000; i++) begin
      bit r, t, c, a, w;
      logic [7:0] d;
      r = ($urandom % 10) != 0;
      t = ($urandom % 2) == 0;
      c = ($urandom % 200) == 0;
      a = ($urandom % 300) == 0;
      w = ($urandom % 20) == 0;
      d = ($urandom % 4 == 0) ? 8'($urandom) : {1'b0, 3'($urandom % 6), 4'($urandom % 10)};
      cyc(r, t, c, a, w, d, "R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule